// File: doc/BRIEF.md
# Parallel-to-Serial Transmit Shifter

This block takes a parallel word of configurable width and sends it out on a single serial line, one bit for each clock cycle in which the enable input is high. The least significant bit goes first. While enable is low the shifter freezes completely. Nothing advances, and no word is taken.

Two single-cycle pulses pace the upstream stage. The `empty_pulse` output warns that the shifter has just put the final bit of the current word on the line. The next enabled cycle will therefore capture a new word from `par_in`. The `get_pulse` output reports that a word was captured on the previous edge, so the source may now present the following word. The serial output and both pulses are driven directly from flip-flops.

Top module: `par_serializer`

## Requirements
- R1: While the synchronous reset `rst` is high, at the next edge `ser_out`, `empty_pulse` and `get_pulse` all go to 0. The first enabled edge after reset captures `par_in`, and no empty pulse comes before that first capture.
- R2: A word is captured from `par_in` only at the enabled edge that follows the edge which put bit WIDTH-1 of the previous word on `ser_out`. Changes on `par_in` at any other time have no effect on the serial stream.
- R3: After a capture, each enabled edge places the next bit of the captured word on `ser_out`, in the order bit 0, bit 1, up to bit WIDTH-1. The capture edge itself presents bit 0.
- R4: At an edge where `enable` is low, `ser_out` keeps its value and the position within the word does not change.
- R5: `get_pulse` is high for exactly the one cycle after each capture edge and is low at all other times.
- R6: `empty_pulse` is high for exactly the one cycle after the enabled edge that places bit WIDTH-1 on `ser_out`. If enable is high at the next edge, that edge is a capture.
- R7: With WIDTH greater than 1, `empty_pulse` and `get_pulse` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows the shifter to advance one step at this edge |
| par_in | input | WIDTH | Parallel word, sampled only at a capture edge |
| ser_out | output | 1 | Serial data, registered |
| empty_pulse | output | 1 | One-cycle warning that the next enabled edge captures a word |
| get_pulse | output | 1 | One-cycle notice that a word was captured at the previous edge |

## Verification
The shifter is driven with `par_in` changing to a new random value on every cycle. This shows that only the value present at a capture edge reaches the line. One phase holds enable high throughout, which checks back-to-back words with no gap between a last bit and the next capture. A second phase toggles enable randomly, which tests stalls that land on the pulse cycles and on the capture edge itself. A third phase drops enable for long runs, which shows that the pulses stay low and the line holds while stalled.

// File: rtl/par_serializer.sv
module par_serializer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic             empty_pulse,
  output logic             get_pulse
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [WIDTH-1:0] shreg;
  logic [CW-1:0]    left;

  wire           reload  = (left == '0);
  wire [CW-1:0]  left_nx = reload ? LAST : left - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg       <= '0;
      left        <= '0;
      ser_out     <= 1'b0;
      empty_pulse <= 1'b0;
      get_pulse   <= 1'b0;
    end else begin
      get_pulse   <= enable && reload;
      empty_pulse <= enable && (left_nx == '0);
      if (enable) begin
        left <= left_nx;
        if (reload) begin
          ser_out <= par_in[0];
          shreg   <= par_in >> 1;
        end else begin
          ser_out <= shreg[0];
          shreg   <= shreg >> 1;
        end
      end
    end
  end

  a_r4_hold_line: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(ser_out) && $stable(left));
  a_r4_no_pulse_stalled: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !empty_pulse && !get_pulse);
  a_r5_get_single: assert property (@(posedge clk) disable iff (rst)
    (WIDTH > 1 && get_pulse) |=> !get_pulse);
  a_r6_empty_then_load: assert property (@(posedge clk) disable iff (rst)
    (empty_pulse && enable) |=> get_pulse);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    (WIDTH > 1) |-> !(empty_pulse && get_pulse));
  a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
    left <= LAST);
endmodule

// File: tb/sim_par_serializer.sv
module sim_par_serializer;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [W-1:0] par_in = '0;
  logic ser_out, empty_pulse, get_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  par_serializer #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .par_in(par_in),
    .ser_out(ser_out), .empty_pulse(empty_pulse), .get_pulse(get_pulse)
  );

  int idx = W - 1;
  logic [W-1:0] word = '0;
  logic m_ser = 1'b0, m_emp = 1'b0, m_get = 1'b0;
  bit m_rst = 0, m_held = 0, m_load = 0;

  always @(posedge clk) begin
    m_rst = rst; m_held = 0; m_load = 0;
    if (rst) begin
      idx = W - 1; m_ser = 1'b0; m_emp = 1'b0; m_get = 1'b0;
    end else if (!enable) begin
      m_held = 1; m_emp = 1'b0; m_get = 1'b0;
    end else begin
      if (idx == W - 1) begin
        word = par_in; idx = 0; m_load = 1;
      end else begin
        idx = idx + 1;
      end
      m_ser = word[idx];
      m_get = m_load;
      m_emp = (idx == W - 1);
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    string t;
    t = m_rst ? "R1" : m_held ? "R4" : m_load ? "R2" : "R3";
    check(t, ser_out, m_ser, "ser_out");
    check(m_rst ? "R1" : "R5", get_pulse, m_get, "get_pulse");
    check(m_rst ? "R1" : "R6", empty_pulse, m_emp, "empty_pulse");
    if (empty_pulse && get_pulse) check("R7", 1'b1, 1'b0, "both pulses");
  endtask

  task automatic step(int en_pct);
    @(negedge clk);
    compare();
    enable = (($urandom % 100) < en_pct);
    par_in = W'($urandom);
  endtask

  initial begin
    repeat (3) step(50);
    @(negedge clk); compare();
    rst = 1'b0;
    for (int i = 0; i < 600; i++) step(100);
    for (int i = 0; i < 1500; i++) step(60);
    for (int i = 0; i < 800; i++) step(8);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step(100);
    rst = 1'b0;
    for (int i = 0; i < 500; i++) step(85);
    @(negedge clk); compare();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule